// File: doc/BRIEF.md
# Processor Trace Port Compressor

This block taps the execute stage of a soft processor and sends a compact trace of every executed instruction to a small group of debug pins. It takes the program counter and an instruction-valid strobe. It drops the address bits that never change or carry no information, and sends the result through a fixed register pipeline so that adding it does not limit timing. It then packs two trace bits onto each pin: one is shown while the clock is high and the other while the clock is low. An external capture instrument latches both halves of every clock period and splits them apart again.

The instrument has to learn which of its channels is wired to which pin. To support this, the block has a training walk. A setup request makes the block drive a fixed 8-bit pattern on one pin at a time, in ascending pin order, while every other pin stays low. When the last pin has been trained, the block raises a one-cycle done pulse and returns to normal trace output.

The trace input is a tap on the processor and cannot be stalled. There is therefore no ready signal. A sample is taken on every rising edge, and back-pressure is never applied to the processor.

Top module: `trc_compress`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, every pin is low in both clock phases and `train_done` is 0.
- R2: Bits [1:0] of `pc_ex` never reach the pins. Two addresses that differ only in those bits produce identical pin values.
- R3: The top STATIC_BITS bits of `pc_ex` (default 12, bits [31:20]) are dropped. Changing only those bits has no effect on the pins.
- R4: The trace word has TB = 31 - STATIC_BITS bits. Bit 0 is the valid flag, and bit i (i ≥ 1) is `pc_ex[i+1]`. Pin k shows word bit 2k while `clk` is high and word bit 2k+1 while `clk` is low. There are ceil(TB/2) pins, which is 10 by default.
- R5: A sample taken at rising edge e reaches the pins on rising edge e + PIPE_DEPTH - 1, after PIPE_DEPTH register stages (default 4). It is not visible on the pins before that edge.
- R6: When `pc_valid` is low, the valid slot is 0 and the address slots repeat the address of the last valid sample.
- R7: When TB is odd, the low-phase slot of the last pin is always 0 during trace output.
- R8: When `setup_req` is high at a rising edge while the block is idle, a training walk starts. From the next edge on, pins 0, 1, … up to the last pin are each trained for TRAIN_CYCLES cycles (default 16). On cycle c of a pin, that pin shows bit 7 - (c mod 8) of 8'b1010_0110 in both clock phases, and all other pins are low.
- R9: A `setup_req` that arrives during a walk is ignored. This includes a request in the cycle that ends the walk. The walk timing is unchanged and no second walk follows.
- R10: `train_done` is high for exactly one cycle, after the edge that ends the last pin's final training cycle. On the next cycle the pins show trace output again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; its level also selects which half of each pin pair is shown |
| rst | input | 1 | Synchronous reset, active high |
| pc_ex | input | 32 | Program counter of the instruction in the execute stage |
| pc_valid | input | 1 | High when `pc_ex` belongs to an executed instruction |
| setup_req | input | 1 | Request to start the channel-training walk |
| trace_pin | output | ceil((31-STATIC_BITS)/2) | Multiplexed trace pins: even word bits while clk is high, odd bits while clk is low |
| train_done | output | 1 | One-cycle pulse at the end of a training walk |

## Verification
Trace capture and the training walk can fall in the same cycle. Trace samples keep entering the pipeline while a walk owns the pins, and a second setup request can land in the walk's final cycle, which is the same cycle the done pulse is produced. The bench keeps valid instructions flowing during a whole walk. It sends extra requests both in the middle of the walk and in its last cycle, and checks every pin in both phases of every training cycle. It then checks that the cycle after the done pulse shows the expected trace word and not a restarted walk.

// File: rtl/trc_pkg.sv
package trc_pkg;
  // Channel-discovery pattern, sent MSB first.
  localparam logic [7:0] TRAIN_PATTERN = 8'b1010_0110;

  // Trace word width: non-static, non-aligned address bits plus a valid flag.
  function automatic int word_bits(int pc_w, int static_bits);
    return pc_w - 2 - static_bits + 1;
  endfunction

  // Two word bits per pin.
  function automatic int pin_count(int pc_w, int static_bits);
    return (word_bits(pc_w, static_bits) + 1) / 2;
  endfunction
endpackage

// File: rtl/trc_reduce.sv
module trc_reduce #(
  parameter int PC_W        = 32,
  parameter int STATIC_BITS = 12,
  localparam int AW         = PC_W - 2 - STATIC_BITS,
  localparam int TB         = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PC_W-1:0] pc_in,
  input  logic          valid_in,
  output logic [TB-1:0] word_q
);
  logic [AW-1:0] addr_q;
  logic          vld_q;

  // Low bits are always zero (word alignment); the top bits are fixed per design.
  logic unused_low;
  assign unused_low = ^pc_in[1:0];
  generate
    if (STATIC_BITS > 0) begin : g_top
      logic unused_top;
      assign unused_top = ^pc_in[PC_W-1:AW+2];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= valid_in;
      if (valid_in) addr_q <= pc_in[AW+1:2];
    end
  end

  assign word_q = {addr_q, vld_q};

  // R6: an idle cycle leaves the captured address untouched
  a_r6_hold_addr: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> $stable(addr_q));
endmodule

// File: rtl/trc_pipe.sv
module trc_pipe #(
  parameter int W      = 19,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES == 0) begin : g_pass
      assign q = d;
    end else begin : g_regs
      logic [W-1:0] stg [STAGES];
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= '0;
          else if (s == 0) stg[s] <= d;
          else stg[s] <= stg[(s == 0) ? 0 : s-1];
        end
      end
      assign q = stg[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/trc_train.sv
module trc_train #(
  parameter int PINS       = 10,
  parameter int CYC        = 16,
  localparam int PW        = (PINS > 1) ? $clog2(PINS) : 1,
  localparam int CW        = ($clog2(CYC) > 3) ? $clog2(CYC) : 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          setup_req,
  output logic          busy,
  output logic [PW-1:0] pin_idx,
  output logic          pat_bit,
  output logic          done
);
  import trc_pkg::*;

  logic [CW-1:0] cnt;
  logic          last_cyc;
  logic          last_pin;

  assign last_cyc = (cnt == CW'(CYC - 1));
  assign last_pin = (pin_idx == PW'(PINS - 1));
  assign pat_bit  = TRAIN_PATTERN[3'd7 - cnt[2:0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      pin_idx <= '0;
      cnt     <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (setup_req) begin
          busy    <= 1'b1;
          pin_idx <= '0;
          cnt     <= '0;
        end
      end else if (last_cyc) begin
        cnt <= '0;
        if (last_pin) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          pin_idx <= pin_idx + 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R10: done is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R10: done only follows a walk that has just ended
  a_r10_done_after_walk: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && !busy));
  // R9: a request mid-walk does not restart or stop it
  a_r9_walk_continues: assert property (@(posedge clk) disable iff (rst)
    (busy && setup_req && !(last_cyc && last_pin)) |=> busy);
  // R8: pins are visited in ascending order
  a_r8_ascending: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (pin_idx >= $past(pin_idx)));
endmodule

// File: rtl/trc_compress.sv
module trc_compress #(
  parameter int PC_W         = 32,
  parameter int STATIC_BITS  = 12,
  parameter int PIPE_DEPTH   = 4,
  parameter int TRAIN_CYCLES = 16,
  localparam int TB          = trc_pkg::word_bits(PC_W, STATIC_BITS),
  localparam int PINS        = trc_pkg::pin_count(PC_W, STATIC_BITS),
  localparam int PW          = (PINS > 1) ? $clog2(PINS) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] pc_ex,
  input  logic            pc_valid,
  input  logic            setup_req,
  output logic [PINS-1:0] trace_pin,
  output logic            train_done
);
  logic [TB-1:0]   word0;
  logic [TB-1:0]   word_late;
  logic [PINS-1:0] rise_d, fall_d, rise_n, fall_n;
  logic [PINS-1:0] rise_q, fall_q;
  logic            train_q;
  logic            busy;
  logic [PW-1:0]   pin_idx;
  logic            pat_bit;

  trc_reduce #(.PC_W(PC_W), .STATIC_BITS(STATIC_BITS)) u_reduce (
    .clk(clk), .rst(rst), .pc_in(pc_ex), .valid_in(pc_valid), .word_q(word0)
  );

  // First stage is in trc_reduce, last stage is the pin register below.
  trc_pipe #(.W(TB), .STAGES(PIPE_DEPTH - 2)) u_pipe (
    .clk(clk), .rst(rst), .d(word0), .q(word_late)
  );

  trc_train #(.PINS(PINS), .CYC(TRAIN_CYCLES)) u_train (
    .clk(clk), .rst(rst), .setup_req(setup_req),
    .busy(busy), .pin_idx(pin_idx), .pat_bit(pat_bit), .done(train_done)
  );

  // Even word bits go to the high phase, odd bits to the low phase.
  generate
    for (genvar k = 0; k < PINS; k++) begin : g_map
      assign rise_d[k] = word_late[2*k];
      if (2*k + 1 < TB) begin : g_pair
        assign fall_d[k] = word_late[2*k+1];
      end else begin : g_pad
        assign fall_d[k] = 1'b0;
      end
      assign rise_n[k] = busy ? ((pin_idx == PW'(k)) & pat_bit) : rise_d[k];
      assign fall_n[k] = busy ? ((pin_idx == PW'(k)) & pat_bit) : fall_d[k];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_q  <= '0;
      fall_q  <= '0;
      train_q <= 1'b0;
    end else begin
      rise_q  <= rise_n;
      fall_q  <= fall_n;
      train_q <= busy;
    end
  end

  // Clock level picks the half of each pair that is on the pin.
  assign trace_pin = clk ? rise_q : fall_q;

  // R8: at most one pin carries the pattern during training
  a_r8_single_pin: assert property (@(posedge clk) disable iff (rst)
    train_q |-> ($countones(rise_q) <= 1 && rise_q == fall_q));
  // R1: no done pulse while no walk has run
  a_r1_quiet_done: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> !train_done);

  generate
    if (TB % 2 == 1) begin : g_odd_chk
      // R7: spare low-phase slot of the last pin stays low in trace mode
      a_r7_pad_zero: assert property (@(posedge clk) disable iff (rst)
        !train_q |-> !fall_q[PINS-1]);
    end
  endgenerate
endmodule

// File: tb/trc_compress_test.sv
`timescale 1ns/1ps
module trc_compress_test;
  localparam int S  = 12;
  localparam int D  = 4;
  localparam int TC = 16;
  localparam int AW = 32 - 2 - S;
  localparam int TB = AW + 1;
  localparam int NP = (TB + 1) / 2;
  localparam logic [7:0] PAT = 8'b1010_0110;
  localparam int NV = 8;
  localparam logic [31:0] VPC [NV] = '{32'h0000_0000, 32'hFFF0_0003, 32'h000F_FFFC,
    32'h0001_2344, 32'h0001_2347, 32'hABC1_2344, 32'h0005_5558, 32'h0002_AAA8};
  localparam logic VV [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, pc_valid, setup_req;
  logic [31:0] pc_ex;
  logic [NP-1:0] trace_pin;
  logic train_done;
  int checks = 0, fails = 0;
  logic ended = 1'b0;
  logic [AW-1:0] hold = '0;

  trc_compress uut (
    .clk(clk), .rst(rst), .pc_ex(pc_ex), .pc_valid(pc_valid),
    .setup_req(setup_req), .trace_pin(trace_pin), .train_done(train_done)
  );

  function automatic logic [TB-1:0] mk_word(logic [31:0] pc, logic v, logic [AW-1:0] h);
    logic [AW-1:0] a;
    a = v ? pc[AW+1:2] : h;
    return {a, v};
  endfunction

  function automatic logic [NP-1:0] hi_slots(logic [TB-1:0] w);
    logic [NP-1:0] r;
    for (int k = 0; k < NP; k++) r[k] = w[2*k];
    return r;
  endfunction

  function automatic logic [NP-1:0] lo_slots(logic [TB-1:0] w);
    logic [NP-1:0] r;
    for (int k = 0; k < NP; k++) r[k] = (2*k + 1 < TB) ? w[2*k+1] : 1'b0;
    return r;
  endfunction

  task automatic chk(string req, logic [NP-1:0] act, logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk1(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Wait for a rising edge, read the high phase, then read the low phase.
  task automatic read_cycle(output logic [NP-1:0] hi, output logic [NP-1:0] lo);
    @(posedge clk); #1 hi = trace_pin;
    @(negedge clk); #1 lo = trace_pin;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!ended) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] hi, lo;
    logic [TB-1:0] w, wx, wy;
    rst = 1'b1; pc_valid = 1'b0; setup_req = 1'b0; pc_ex = '0;

    // R1: quiet pins during reset
    read_cycle(hi, lo);
    read_cycle(hi, lo);
    chk("R1 reset high phase", hi, '0);
    chk("R1 reset low phase", lo, '0);
    chk1("R1 reset done", train_done, 1'b0);
    rst = 1'b0;
    read_cycle(hi, lo);
    chk("R1 first cycle after reset", hi | lo, '0);

    // Table walk: R2, R3, R4, R6, R7
    for (int i = 0; i < NV; i++) begin
      pc_ex = VPC[i]; pc_valid = VV[i];
      w = mk_word(VPC[i], VV[i], hold);
      if (VV[i]) hold = VPC[i][AW+1:2];
      repeat (D - 1) @(posedge clk);
      read_cycle(hi, lo);
      chk($sformatf("R4 vec%0d high slots (R2 R3 R6)", i), hi, hi_slots(w));
      chk($sformatf("R4 vec%0d low slots (R7 pad)", i), lo, lo_slots(w));
    end

    // R2 and R3 directly: only aligned-low and static-top bits set
    pc_ex = 32'hFFF0_0003; pc_valid = 1'b1;
    repeat (D - 1) @(posedge clk);
    read_cycle(hi, lo);
    chk("R2 R3 ignored bits high", hi, NP'(1));
    chk("R2 R3 ignored bits low", lo, '0);
    chk1("R7 last pin low slot", lo[NP-1], 1'b0);
    hold = '0;

    // R5: exact latency
    pc_ex = 32'h0000_1110; pc_valid = 1'b1;
    wx = mk_word(pc_ex, 1'b1, hold);
    repeat (D + 1) @(posedge clk);
    @(negedge clk);
    pc_ex = 32'h000E_EEEC;
    wy = mk_word(pc_ex, 1'b1, hold);
    hold = pc_ex[AW+1:2];
    for (int k = 1; k <= D; k++) begin
      read_cycle(hi, lo);
      if (k < D) chk($sformatf("R5 edge %0d still old", k), hi, hi_slots(wx));
      else begin
        chk("R5 new word high", hi, hi_slots(wy));
        chk("R5 new word low", lo, lo_slots(wy));
      end
    end

    // R8 R9 R10: training walk with trace flowing and extra requests
    setup_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    setup_req = 1'b0;
    for (int p = 0; p < NP; p++) begin
      for (int c = 0; c < TC; c++) begin
        logic [NP-1:0] e;
        logic last;
        e = '0;
        e[p] = PAT[7 - (c % 8)];
        last = (p == NP - 1) && (c == TC - 1);
        @(posedge clk); #1 hi = trace_pin;
        chk($sformatf("R8 pin%0d cyc%0d high", p, c), hi, e);
        chk1($sformatf("R10 done at pin%0d cyc%0d", p, c), train_done, last);
        @(negedge clk); #1 lo = trace_pin;
        chk($sformatf("R8 pin%0d cyc%0d low", p, c), lo, e);
        // R9: requests mid-walk and in the final walk cycle
        setup_req = ((p == 3) && (c == 5)) ||
                    ((p == NP - 1) && (c == TC - 2));
      end
    end
    setup_req = 1'b0;
    read_cycle(hi, lo);
    chk1("R10 done is one cycle", train_done, 1'b0);
    chk("R10 R9 trace resumes high", hi, hi_slots(wy));
    chk("R10 R9 trace resumes low", lo, lo_slots(wy));
    read_cycle(hi, lo);
    chk("R9 no second walk", hi, hi_slots(wy));

    // R6 after training: idle cycles keep the last address
    pc_valid = 1'b0; pc_ex = 32'h0003_3330;
    w = mk_word(pc_ex, 1'b0, hold);
    repeat (D - 1) @(posedge clk);
    read_cycle(hi, lo);
    chk("R6 idle high", hi, hi_slots(w));
    chk("R6 idle low", lo, lo_slots(w));

    ended = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule